// File: doc/BRIEF.md
# Bit Error Rate Measurement Counters

This block holds the counters on the receive side of a bit error rate tester. One running counter counts receive-clock cycles in which a bit is accepted for measurement. A second running counter counts the bits that the upstream pattern synchronizer reports as wrong. Both counters advance only while the synchronizer reports lock and reception is not disabled. Outside those conditions they freeze, so lost-sync periods never dilute the measured ratio.

A snapshot request copies both running counts into held output registers and restarts the counters, both in the same cycle. The host then reads the pair and divides one by the other to get the error rate. The request is the OR of a pin and a control bit, and only its rising edge acts. The length of each integration period is therefore set entirely by the host. Three sticky flags record counter wrap-around and the presence of any counted error. A read strobe clears all three.

Top module: `ber_tally`

## Requirements
- R1: While `rx_hold` is low and `in_lock` is high, the bit counter advances by exactly one on every clock.
- R2: While `rx_hold` is high or `in_lock` is low, neither counter advances. An error pulse in such a cycle is not counted and does not set `err_seen`.
- R3: The error counter advances by one on each clock where `miss_bit` is high and counting is enabled as in R1.
- R4: A rising edge of the request (`snap_pin` OR `snap_ctl`, high this cycle and low the previous cycle) loads `held_bits` and `held_errs` with the running counts as they stood before that cycle's increment. The new values are visible one clock later. The held outputs do not change on any other cycle.
- R5: In the cycle of a snapshot edge, each running counter restarts at that cycle's own increment, so it holds 1 if it advanced in that cycle and 0 if not.
- R6: A request that stays high produces only one snapshot; it must go low before another edge is seen. A request already high when reset is released is not an edge.
- R7: A running counter of CNT_W bits (32 by default) that advances past its all-ones value wraps to zero and keeps counting. The wrap sets `bits_wrap` or `errs_wrap`, one clock later. Advancing on a snapshot cycle is never a wrap.
- R8: `err_seen` is set one clock after any counted error.
- R9: A `flag_rd` pulse clears every flag one clock later, except a flag whose setting event happens in that same cycle; that flag stays set.
- R10: After reset both held counts are zero and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_hold | input | 1 | Receive disable; high freezes the counters |
| in_lock | input | 1 | Synchronizer lock status |
| miss_bit | input | 1 | Current received bit is in error |
| snap_pin | input | 1 | Snapshot request, pin source |
| snap_ctl | input | 1 | Snapshot request, control-bit source |
| flag_rd | input | 1 | Flag read strobe; clears the sticky flags |
| held_bits | output | CNT_W | Bit count captured at the last snapshot |
| held_errs | output | CNT_W | Error count captured at the last snapshot |
| bits_wrap | output | 1 | Sticky: bit counter wrapped |
| errs_wrap | output | 1 | Sticky: error counter wrapped |
| err_seen | output | 1 | Sticky: a counted error occurred |

## Verification
On every cycle, the assertions check four things. Held values change only on a snapshot edge, and then take the prior running count. A counter with no increment and no snapshot stays put. Errors are never counted without the bit counter advancing. Flags obey the priority of a set over a read clear. Other behaviour shows up only in the bench's scenarios, because the running counts are not outputs and can be seen only through a later snapshot. This covers the exact totals over mixed enable patterns, the single snapshot from a request held high, and wrap-around at the counter limit.

// File: rtl/ber_tally_pkg.sv
package ber_tally_pkg;
  // Index of each sticky flag inside the flag bank
  typedef enum int {
    FLG_BITS_WRAP = 0,
    FLG_ERRS_WRAP = 1,
    FLG_ERR_SEEN  = 2
  } flag_idx_e;

  localparam int NUM_FLAGS = 3;
  localparam int NUM_CNTS  = 2;

  // Rising-edge test used by the snapshot detector
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur && !prev;
  endfunction

  // Next sticky value: a set wins over a read clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/ber_snap_edge.sv
module ber_snap_edge
  import ber_tally_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic edge_pulse
);
  logic prev_q;

  assign edge_pulse = rise_of(req, prev_q);

  // prev resets high: a request held through reset is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= req;
  end

  AST_ONE_SNAP_PER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse); // R6
  AST_NO_EDGE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req) && req) |-> !edge_pulse); // R6
endmodule

// File: rtl/ber_run_counter.sv
module ber_run_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         snap,
  output logic [W-1:0] held_q,
  output logic         wrap_evt
);
  logic [W-1:0] run_q;
  logic [W:0]   nxt;

  // Increment with carry out; carry marks a wrap past all-ones
  function automatic logic [W:0] step(input logic [W-1:0] v, input logic i);
    return {1'b0, v} + (W+1)'(i);
  endfunction

  assign nxt      = step(run_q, inc);
  assign wrap_evt = nxt[W] && !snap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      held_q <= '0;
    end else if (snap) begin
      held_q <= run_q;
      run_q  <= {{(W-1){1'b0}}, inc};
    end else begin
      run_q  <= nxt[W-1:0];
    end
  end

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !snap) |=> $stable(run_q)); // R2
  AST_SNAP_TAKES_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> held_q == $past(run_q)); // R4
  AST_HELD_ONLY_ON_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(held_q)); // R4
  AST_RESTART_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> run_q == {{(W-1){1'b0}}, $past(inc)}); // R5
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> run_q == '0); // R7
endmodule

// File: rtl/ber_sticky_flag.sv
module ber_sticky_flag
  import ber_tally_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= sticky_next(flag_q, set, clr);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q); // R9
  AST_HOLDS_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R9
endmodule

// File: rtl/ber_tally.sv
module ber_tally
  import ber_tally_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_hold,
  input  logic             in_lock,
  input  logic             miss_bit,
  input  logic             snap_pin,
  input  logic             snap_ctl,
  input  logic             flag_rd,
  output logic [CNT_W-1:0] held_bits,
  output logic [CNT_W-1:0] held_errs,
  output logic             bits_wrap,
  output logic             errs_wrap,
  output logic             err_seen
);
  logic                count_en;
  logic                bit_inc;
  logic                err_inc;
  logic                snap_evt;
  logic [NUM_CNTS-1:0] inc_vec;
  logic [NUM_CNTS-1:0] wrap_vec;
  logic [CNT_W-1:0]    held_arr [NUM_CNTS];
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_vec;

  assign count_en = !rx_hold && in_lock;
  assign bit_inc  = count_en;
  assign err_inc  = count_en && miss_bit;
  assign inc_vec  = {err_inc, bit_inc};

  ber_snap_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (snap_pin | snap_ctl),
    .edge_pulse (snap_evt)
  );

  for (genvar g = 0; g < NUM_CNTS; g++) begin : g_cnt
    ber_run_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc_vec[g]),
      .snap     (snap_evt),
      .held_q   (held_arr[g]),
      .wrap_evt (wrap_vec[g])
    );
  end

  assign set_vec[FLG_BITS_WRAP] = wrap_vec[0];
  assign set_vec[FLG_ERRS_WRAP] = wrap_vec[1];
  assign set_vec[FLG_ERR_SEEN]  = err_inc;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    ber_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (set_vec[f]),
      .clr    (flag_rd),
      .flag_q (flag_vec[f])
    );
  end

  assign held_bits = held_arr[0];
  assign held_errs = held_arr[1];
  assign bits_wrap = flag_vec[FLG_BITS_WRAP];
  assign errs_wrap = flag_vec[FLG_ERRS_WRAP];
  assign err_seen  = flag_vec[FLG_ERR_SEEN];

  AST_ERR_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    err_inc |-> bit_inc); // R3
  AST_SEEN_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_inc |=> err_seen); // R8
  AST_ERR_WRAP_NEEDS_BIT_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_vec[1] |-> bit_inc); // R7
endmodule

// File: tb/ber_tally_test.sv
module ber_tally_test;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_hold = 1'b0, in_lock = 1'b0, miss_bit = 1'b0;
  logic snap_pin = 1'b0, snap_ctl = 1'b0, flag_rd = 1'b0;
  logic [TW-1:0] held_bits, held_errs;
  logic bits_wrap, errs_wrap, err_seen;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model state
  logic [TW-1:0] m_rb, m_re, m_hb, m_he;
  logic m_fb, m_fe, m_fs, m_prev;

  always #2 clk = ~clk;

  ber_tally #(.CNT_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .rx_hold(rx_hold), .in_lock(in_lock),
    .miss_bit(miss_bit), .snap_pin(snap_pin), .snap_ctl(snap_ctl),
    .flag_rd(flag_rd), .held_bits(held_bits), .held_errs(held_errs),
    .bits_wrap(bits_wrap), .errs_wrap(errs_wrap), .err_seen(err_seen)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic sticky(input logic cur, input logic ev, input logic rd);
    if (ev) return 1'b1;
    if (rd) return 1'b0;
    return cur;
  endfunction

  task automatic model_reset();
    m_rb = '0; m_re = '0; m_hb = '0; m_he = '0;
    m_fb = 0; m_fe = 0; m_fs = 0; m_prev = 1'b1;
  endtask

  // Apply the rules of R1..R9 to the inputs of one clock
  task automatic model_step();
    logic en, ib, ie, req, ed, wb, we;
    en  = !rx_hold && in_lock;
    ib  = en;
    ie  = en && miss_bit;
    req = snap_pin || snap_ctl;
    ed  = req && !m_prev;
    wb  = 0; we = 0;
    if (ed) begin
      m_hb = m_rb; m_he = m_re;
      m_rb = TW'(ib); m_re = TW'(ie);
    end else begin
      if (ib) begin wb = (m_rb == '1); m_rb = m_rb + 1'b1; end
      if (ie) begin we = (m_re == '1); m_re = m_re + 1'b1; end
    end
    m_fb = sticky(m_fb, wb, flag_rd);
    m_fe = sticky(m_fe, we, flag_rd);
    m_fs = sticky(m_fs, ie, flag_rd);
    m_prev = req;
  endtask

  task automatic compare_all();
    chk("R1 R4 held_bits", 32'(held_bits), 32'(m_hb));
    chk("R3 R4 held_errs", 32'(held_errs), 32'(m_he));
    chk("R7 R9 bits_wrap", 32'(bits_wrap), 32'(m_fb));
    chk("R7 R9 errs_wrap", 32'(errs_wrap), 32'(m_fe));
    chk("R8 R9 err_seen",  32'(err_seen),  32'(m_fs));
  endtask

  task automatic cyc(input logic h, input logic l, input logic m,
                     input logic p, input logic c, input logic r);
    @(negedge clk);
    rx_hold = h; in_lock = l; miss_bit = m;
    snap_pin = p; snap_ctl = c; flag_rd = r;
    @(posedge clk);
    #1;
    model_step();
    compare_all();
  endtask

  // Snapshot pulse through the control bit, then release
  task automatic snap_now();
    cyc(1, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1717));
    model_reset();
    // R6: request high across reset release is not an edge
    snap_pin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R10 held_bits", 32'(held_bits), 0);
    chk("R10 held_errs", 32'(held_errs), 0);
    chk("R10 flags", 32'({bits_wrap, errs_wrap, err_seen}), 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, 0, 0);
    chk("R6 no snapshot after reset", 32'(held_bits), 0);
    cyc(1, 1, 0, 0, 0, 0);
    snap_now();
    chk("R6 R3 first snapshot bits", 32'(held_bits), 5);
    chk("R3 first snapshot errs", 32'(held_errs), 5);

    // R2: disabled or unlocked, errors ignored
    cyc(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0);
    chk("R2 err_seen stays low", 32'(err_seen), 0);
    snap_now();
    chk("R2 frozen bits", 32'(held_bits), 0);
    chk("R2 frozen errs", 32'(held_errs), 0);

    // R1 R3: ten counted bits, every other in error
    for (int i = 0; i < 10; i++) cyc(0, 1, i[0], 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0);
    snap_now();
    chk("R1 ten bits", 32'(held_bits), 10);
    chk("R3 five errors", 32'(held_errs), 5);

    // R5: snapshot during a counted error cycle restarts at one
    cyc(0, 1, 1, 0, 0, 0);
    cyc(0, 1, 1, 1, 0, 0);
    chk("R4 prior count taken", 32'(held_bits), 1);
    // R6: pin stays high, no second snapshot
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 1, 0);
    chk("R6 held unchanged", 32'(held_bits), 1);
    cyc(1, 1, 0, 0, 0, 0);
    snap_now();
    chk("R5 restart counted", 32'(held_bits), 5);
    chk("R5 restart error", 32'(held_errs), 1);

    // R9: read in the same cycle as an error keeps err_seen
    cyc(0, 1, 1, 0, 0, 1);
    chk("R9 set wins over read", 32'(err_seen), 1);
    cyc(1, 1, 0, 0, 0, 1);
    chk("R9 read clears", 32'(err_seen), 0);

    // R7: drive all errors past the limit
    snap_now();
    for (int i = 0; i < 260; i++) cyc(0, 1, 1, 0, 0, 0);
    chk("R7 bit wrap flag", 32'(bits_wrap), 1);
    chk("R7 err wrap flag", 32'(errs_wrap), 1);
    cyc(1, 1, 0, 0, 0, 0);
    snap_now();
    chk("R7 wrapped count", 32'(held_bits), 4);

    // R7: snapshot exactly at all-ones is not a wrap
    cyc(1, 1, 0, 0, 0, 1);
    for (int i = 0; i < 255; i++) cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 1, 0);
    chk("R7 no wrap on snapshot", 32'(bits_wrap), 0);
    chk("R7 all-ones captured", 32'(held_bits), 255);

    // Random mix checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      logic h, l, m, p, c, r;
      h = ($urandom % 8) == 0;
      l = ($urandom % 10) != 0;
      m = ($urandom % 4) == 0;
      p = ($urandom % 40) == 0;
      c = ($urandom % 50) == 0;
      r = ($urandom % 30) == 0;
      cyc(h, l, m, p, c, r);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule